// File: doc/BRIEF.md
# Page-Grid Address Translation Unit

This block turns an incoming address into a fabric destination (subnet and component identifiers) and a remote memory address. Software programs a small set of grid descriptors, each describing a contiguous window made of equal pages of a selectable power-of-two size, together with a table of page entries. Each grid points at a run of consecutive entries: page `k` of a grid uses entry `base + k`.

A lookup is accepted through a valid/ready handshake. In the acceptance cycle the unit compares the address against every enabled grid, computes the entry index and starts the synchronous entry read. In the following cycle it checks the entry, forms the remote address and loads the registered response. The response leaves through a second valid/ready handshake. A fault flag with a two-bit cause replaces the data when translation is not possible. Configuration writes to grids and entries use two separate write strobes and take effect for lookups accepted after the write edge.

Top module: `pgx_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, and every grid is disabled, so any lookup faults with cause 0.
- R2: Grid `g` matches address `a` when it is enabled and `start <= a < start + count * 2^lg`. If no enabled grid matches, the unit reports a fault with cause 0 (no grid).
- R3: When several enabled grids match, the one with the lowest number is used. A disabled grid never matches, even when it has a lower number.
- R4: The entry index is `base + ((a - start) >> lg)`. An index of 256 or more gives a fault with cause 1 (index beyond table).
- R5: Selecting an entry whose valid bit is clear gives a fault with cause 2 (invalid entry). Entries are invalid after reset.
- R6: A write request (`req_write`=1) to a valid entry with its write-enable bit clear gives a fault with cause 3 (write denied). Read requests ignore that bit. When several fault conditions hold, the cause is chosen in the priority order 0, 1, 2, 3.
- R7: A request without a fault returns `rsp_addr = rbase | (a & (2^lg - 1))`, together with the entry's subnet, component, key and read-enable bit. On a fault, `rsp_fault`=1 and the subnet, component, address, key and read-enable outputs are all 0. Without a fault, `rsp_fault`=0 and `rsp_cause`=0.
- R8: A grid write whose log2 page size lies outside 12..30 is ignored, and the descriptor keeps its previous start, size, count, base and enable.
- R9: A request accepted at a clock edge has its response visible on `rsp_valid` after the next clock edge. Responses come out in acceptance order, one for each accepted request.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, all response outputs hold steady. While `rsp_ready` stays 1, the unit accepts one request on every cycle.
- R11: A lookup accepted on the same edge as a grid or entry write uses the old contents. A lookup accepted on a later edge uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_grid_we | input | 1 | Grid descriptor write strobe |
| cfg_grid_sel | input | 3 | Grid number to write |
| cfg_grid_start | input | 64 | Grid start address |
| cfg_grid_lg | input | 5 | log2 page size (12..30) |
| cfg_grid_cnt | input | 20 | Number of pages in the grid |
| cfg_grid_base | input | 8 | First entry index used by the grid |
| cfg_grid_en | input | 1 | Grid enable |
| cfg_ent_we | input | 1 | Entry write strobe |
| cfg_ent_idx | input | 8 | Entry number to write |
| cfg_ent_valid | input | 1 | Entry valid bit |
| cfg_ent_subnet | input | 16 | Destination subnet identifier |
| cfg_ent_comp | input | 12 | Destination component identifier |
| cfg_ent_rbase | input | 64 | Page-aligned remote base address |
| cfg_ent_rd | input | 1 | Read-enable bit (passed through) |
| cfg_ent_wr | input | 1 | Write-enable bit |
| cfg_ent_key | input | 32 | Key passed through to the response |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high with req_valid |
| req_addr | input | 64 | Address to translate |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_fault | output | 1 | Translation fault |
| rsp_cause | output | 2 | Fault cause: 0 no grid, 1 index beyond table, 2 invalid entry, 3 write denied |
| rsp_subnet | output | 16 | Destination subnet identifier |
| rsp_comp | output | 12 | Destination component identifier |
| rsp_addr | output | 64 | Remote address |
| rsp_key | output | 32 | Entry key |
| rsp_rd_en | output | 1 | Entry read-enable bit |

## Verification
A configuration write and a lookup acceptance can happen on the same clock edge. The bench drives a grid write and an entry write in the same cycle as a request that depends on them. The scoreboard expects the old translation for that request and the new translation for a repeat lookup on the next cycle. The other collision is a new acceptance while the response is stalled. Random `rsp_ready` backpressure provokes it. The bench then judges that the held response stays unchanged and that no request is lost or reordered.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int LG_W = 5;
  localparam logic [LG_W-1:0] LG_MIN = 5'd12;
  localparam logic [LG_W-1:0] LG_MAX = 5'd30;

  typedef enum logic [1:0] {
    CZ_NOGRID  = 2'd0,
    CZ_RANGE   = 2'd1,
    CZ_INVALID = 2'd2,
    CZ_NOWRITE = 2'd3
  } cause_e;
endpackage

// File: rtl/pgx_grid_match.sv
module pgx_grid_match
  import pgx_pkg::*;
#(
  parameter int AW     = 64,
  parameter int NGRID  = 8,
  parameter int CNT_W  = 20,
  parameter int IDX_W  = 8,
  parameter int SUM_W  = 21,
  parameter int GSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [GSEL_W-1:0] wr_sel,
  input  logic [AW-1:0]     wr_start,
  input  logic [LG_W-1:0]   wr_lg,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic [IDX_W-1:0]  wr_base,
  input  logic              wr_enable,
  input  logic [AW-1:0]     lk_addr,
  output logic              lk_hit,
  output logic [SUM_W-1:0]  lk_idx,
  output logic [AW-1:0]     lk_mask
);
  logic              lg_ok;
  logic [NGRID-1:0]  hit_v;
  logic [SUM_W-1:0]  sum_v  [NGRID];
  logic [AW-1:0]     mask_v [NGRID];

  assign lg_ok = (wr_lg >= LG_MIN) && (wr_lg <= LG_MAX);

  for (genvar g = 0; g < NGRID; g++) begin : g_grid
    logic             en_q;
    logic [AW-1:0]    start_q;
    logic [LG_W-1:0]  lg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] base_q;
    logic [AW-1:0]    pg;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q    <= 1'b0;
        start_q <= '0;
        lg_q    <= LG_MIN;
        cnt_q   <= '0;
        base_q  <= '0;
      end else if (wr_en && (wr_sel == GSEL_W'(g)) && lg_ok) begin
        en_q    <= wr_enable;
        start_q <= wr_start;
        lg_q    <= wr_lg;
        cnt_q   <= wr_cnt;
        base_q  <= wr_base;
      end
    end

    // page number relative to the grid start; compared to count to avoid overflow of start+size
    assign pg        = (lk_addr - start_q) >> lg_q;
    assign hit_v[g]  = en_q && (lk_addr >= start_q) && (pg < AW'(cnt_q));
    assign sum_v[g]  = SUM_W'(base_q) + SUM_W'(pg[CNT_W-1:0]);
    assign mask_v[g] = (AW'(1) << lg_q) - AW'(1);
  end

  // lowest-numbered matching grid wins
  always_comb begin
    lk_hit  = 1'b0;
    lk_idx  = '0;
    lk_mask = '0;
    for (int g = NGRID - 1; g >= 0; g--) begin
      if (hit_v[g]) begin
        lk_hit  = 1'b1;
        lk_idx  = sum_v[g];
        lk_mask = mask_v[g];
      end
    end
  end
endmodule

// File: rtl/pgx_entry_ram.sv
module pgx_entry_ram #(
  parameter int DEPTH = 256,
  parameter int IDX_W = 8,
  parameter int DW    = 126
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic             wvalid,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic             rvalid,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vbits;

  // data array: plain read-first RAM with read enable, no reset
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  // valid bits live in flops so that the table starts empty
  always_ff @(posedge clk) begin
    if (rst) begin
      vbits  <= '0;
      rvalid <= 1'b0;
    end else begin
      if (we) vbits[waddr] <= wvalid;
      if (re) rvalid <= vbits[raddr];
    end
  end
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
  import pgx_pkg::*;
#(
  parameter int AW    = 64,
  parameter int NGRID = 8,
  parameter int NENT  = 256,
  parameter int CNT_W = 20,
  parameter int SUB_W = 16,
  parameter int CID_W = 12,
  parameter int KEY_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_grid_we,
  input  logic [$clog2(NGRID)-1:0]  cfg_grid_sel,
  input  logic [AW-1:0]             cfg_grid_start,
  input  logic [4:0]                cfg_grid_lg,
  input  logic [CNT_W-1:0]          cfg_grid_cnt,
  input  logic [$clog2(NENT)-1:0]   cfg_grid_base,
  input  logic                      cfg_grid_en,
  input  logic                      cfg_ent_we,
  input  logic [$clog2(NENT)-1:0]   cfg_ent_idx,
  input  logic                      cfg_ent_valid,
  input  logic [SUB_W-1:0]          cfg_ent_subnet,
  input  logic [CID_W-1:0]          cfg_ent_comp,
  input  logic [AW-1:0]             cfg_ent_rbase,
  input  logic                      cfg_ent_rd,
  input  logic                      cfg_ent_wr,
  input  logic [KEY_W-1:0]          cfg_ent_key,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [AW-1:0]             req_addr,
  input  logic                      req_write,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic                      rsp_fault,
  output logic [1:0]                rsp_cause,
  output logic [SUB_W-1:0]          rsp_subnet,
  output logic [CID_W-1:0]          rsp_comp,
  output logic [AW-1:0]             rsp_addr,
  output logic [KEY_W-1:0]          rsp_key,
  output logic                      rsp_rd_en
);
  localparam int GSEL_W = $clog2(NGRID);
  localparam int IDX_W  = $clog2(NENT);
  localparam int SUM_W  = ((IDX_W > CNT_W) ? IDX_W : CNT_W) + 1;
  localparam int DW     = SUB_W + CID_W + AW + 2 + KEY_W;

  logic             accept, out_free;
  logic             lk_hit;
  logic [SUM_W-1:0] lk_idx;
  logic [AW-1:0]    lk_mask;

  logic             s1_v, s1_hit, s1_inrange, s1_write;
  logic [AW-1:0]    s1_off;

  logic             ent_v;
  logic [DW-1:0]    ent_d;
  logic [SUB_W-1:0] e_sub;
  logic [CID_W-1:0] e_cid;
  logic [AW-1:0]    e_rbase;
  logic             e_rd, e_wr;
  logic [KEY_W-1:0] e_key;

  logic             f_fault;
  cause_e           f_cause;

  assign out_free  = !rsp_valid || rsp_ready;
  assign req_ready = !s1_v || out_free;
  assign accept    = req_valid && req_ready;

  pgx_grid_match #(
    .AW(AW), .NGRID(NGRID), .CNT_W(CNT_W), .IDX_W(IDX_W),
    .SUM_W(SUM_W), .GSEL_W(GSEL_W)
  ) u_match (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_grid_we),
    .wr_sel   (cfg_grid_sel),
    .wr_start (cfg_grid_start),
    .wr_lg    (cfg_grid_lg),
    .wr_cnt   (cfg_grid_cnt),
    .wr_base  (cfg_grid_base),
    .wr_enable(cfg_grid_en),
    .lk_addr  (req_addr),
    .lk_hit   (lk_hit),
    .lk_idx   (lk_idx),
    .lk_mask  (lk_mask)
  );

  pgx_entry_ram #(.DEPTH(NENT), .IDX_W(IDX_W), .DW(DW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_ent_we),
    .waddr (cfg_ent_idx),
    .wvalid(cfg_ent_valid),
    .wdata ({cfg_ent_subnet, cfg_ent_comp, cfg_ent_rbase,
             cfg_ent_rd, cfg_ent_wr, cfg_ent_key}),
    .re    (accept),
    .raddr (lk_idx[IDX_W-1:0]),
    .rvalid(ent_v),
    .rdata (ent_d)
  );

  // stage 1: match result captured at acceptance, together with the entry read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
    end else if (req_ready) begin
      s1_v <= req_valid;
    end
    if (accept) begin
      s1_hit     <= lk_hit;
      s1_inrange <= (lk_idx < SUM_W'(NENT));
      s1_write   <= req_write;
      s1_off     <= req_addr & lk_mask;
    end
  end

  assign {e_sub, e_cid, e_rbase, e_rd, e_wr, e_key} = ent_d;

  always_comb begin
    f_fault = 1'b1;
    f_cause = CZ_NOGRID;
    if (!s1_hit)                f_cause = CZ_NOGRID;
    else if (!s1_inrange)       f_cause = CZ_RANGE;
    else if (!ent_v)            f_cause = CZ_INVALID;
    else if (s1_write && !e_wr) f_cause = CZ_NOWRITE;
    else begin
      f_fault = 1'b0;
      f_cause = CZ_NOGRID;
    end
  end

  // stage 2: registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_cause  <= '0;
      rsp_subnet <= '0;
      rsp_comp   <= '0;
      rsp_addr   <= '0;
      rsp_key    <= '0;
      rsp_rd_en  <= 1'b0;
    end else if (out_free) begin
      rsp_valid <= s1_v;
      if (s1_v) begin
        rsp_fault  <= f_fault;
        rsp_cause  <= f_cause;
        rsp_subnet <= f_fault ? '0 : e_sub;
        rsp_comp   <= f_fault ? '0 : e_cid;
        rsp_addr   <= f_fault ? '0 : (e_rbase | s1_off);
        rsp_key    <= f_fault ? '0 : e_key;
        rsp_rd_en  <= f_fault ? 1'b0 : e_rd;
      end
    end
  end
endmodule

// File: rtl/pgx_xlate_chk.sv
module pgx_xlate_chk #(
  parameter int AW    = 64,
  parameter int SUB_W = 16,
  parameter int CID_W = 12,
  parameter int KEY_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_fault,
  input logic [1:0]       rsp_cause,
  input logic [SUB_W-1:0] rsp_subnet,
  input logic [CID_W-1:0] rsp_comp,
  input logic [AW-1:0]    rsp_addr,
  input logic [KEY_W-1:0] rsp_key
);
  logic [1:0] pending;
  logic       in_fire, out_fire;

  assign in_fire  = req_valid && req_ready;
  assign out_fire = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= pending + 2'(in_fire) - 2'(out_fire);
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) $past(rst) |-> !rsp_valid);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)
      && $stable(rsp_cause) && $stable(rsp_key) && $stable(rsp_subnet) && $stable(rsp_comp));

  // R10
  ready_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> req_ready);

  // R7
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> (rsp_subnet == '0) && (rsp_comp == '0)
      && (rsp_addr == '0) && (rsp_key == '0));

  // R7
  clean_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rsp_cause == 2'd0);

  // R9
  pending_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pending <= 2'd2);

  // R9
  rsp_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> pending != 2'd0);
endmodule

bind pgx_xlate pgx_xlate_chk #(.AW(AW), .SUB_W(SUB_W), .CID_W(CID_W), .KEY_W(KEY_W)) u_chk (.*);

// File: tb/pgx_xlate_bench.sv
module pgx_xlate_bench;
  typedef struct packed {
    logic        fault;
    logic [1:0]  cause;
    logic [15:0] sub;
    logic [11:0] cid;
    logic [63:0] addr;
    logic [31:0] key;
    logic        rd;
  } exp_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        cfg_grid_we = 0;
  logic [2:0]  cfg_grid_sel = 0;
  logic [63:0] cfg_grid_start = 0;
  logic [4:0]  cfg_grid_lg = 0;
  logic [19:0] cfg_grid_cnt = 0;
  logic [7:0]  cfg_grid_base = 0;
  logic        cfg_grid_en = 0;
  logic        cfg_ent_we = 0;
  logic [7:0]  cfg_ent_idx = 0;
  logic        cfg_ent_valid = 0;
  logic [15:0] cfg_ent_subnet = 0;
  logic [11:0] cfg_ent_comp = 0;
  logic [63:0] cfg_ent_rbase = 0;
  logic        cfg_ent_rd = 0, cfg_ent_wr = 0;
  logic [31:0] cfg_ent_key = 0;
  logic        req_valid = 0, req_write = 0;
  logic [63:0] req_addr = 0;
  logic        req_ready;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic        rsp_fault, rsp_rd_en;
  logic [1:0]  rsp_cause;
  logic [15:0] rsp_subnet;
  logic [11:0] rsp_comp;
  logic [63:0] rsp_addr;
  logic [31:0] rsp_key;

  pgx_xlate u_pgx_xlate (.*);

  int checks = 0, errors = 0;
  bit bp = 0, done = 0;
  logic [7:0] lfsr = 8'hA5;

  // bench-side model of the programmed state
  logic        g_en [8];
  logic [63:0] g_start [8];
  logic [4:0]  g_lg [8];
  logic [19:0] g_cnt [8];
  logic [7:0]  g_base [8];
  logic        m_v [256];
  logic [15:0] m_sub [256];
  logic [11:0] m_cid [256];
  logic [63:0] m_rb [256];
  logic        m_rd [256], m_wr [256];
  logic [31:0] m_key [256];

  exp_t  q_exp [$];
  string q_tag [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [63:0] a, input logic w);
    exp_t e;
    int gsel;
    logic [63:0] spg, idx;
    e = '0; gsel = -1; spg = 0;
    for (int g = 0; g < 8; g++) begin
      if (gsel < 0 && g_en[g] && a >= g_start[g]) begin
        logic [63:0] pg;
        pg = (a - g_start[g]) >> g_lg[g];
        if (pg < 64'(g_cnt[g])) begin gsel = g; spg = pg; end
      end
    end
    e.fault = 1'b1;
    if (gsel < 0) e.cause = 2'd0;
    else begin
      idx = 64'(g_base[gsel]) + spg;
      if (idx >= 64'd256) e.cause = 2'd1;
      else if (!m_v[idx[7:0]]) e.cause = 2'd2;
      else if (w && !m_wr[idx[7:0]]) e.cause = 2'd3;
      else begin
        e.fault = 1'b0;
        e.sub   = m_sub[idx[7:0]];
        e.cid   = m_cid[idx[7:0]];
        e.addr  = m_rb[idx[7:0]] | (a & ((64'd1 << g_lg[gsel]) - 64'd1));
        e.key   = m_key[idx[7:0]];
        e.rd    = m_rd[idx[7:0]];
      end
    end
    return e;
  endfunction

  task automatic set_grid(input int g, input logic [63:0] st, input logic [4:0] lg,
                          input logic [19:0] cnt, input logic [7:0] base, input logic en);
    cfg_grid_we = 1; cfg_grid_sel = 3'(g); cfg_grid_start = st; cfg_grid_lg = lg;
    cfg_grid_cnt = cnt; cfg_grid_base = base; cfg_grid_en = en;
  endtask

  task automatic commit_grid();
    if (cfg_grid_lg >= 5'd12 && cfg_grid_lg <= 5'd30) begin
      g_en[cfg_grid_sel] = cfg_grid_en; g_start[cfg_grid_sel] = cfg_grid_start;
      g_lg[cfg_grid_sel] = cfg_grid_lg; g_cnt[cfg_grid_sel] = cfg_grid_cnt;
      g_base[cfg_grid_sel] = cfg_grid_base;
    end
  endtask

  task automatic set_ent(input int i, input logic v, input logic [15:0] s,
                         input logic [11:0] c, input logic [63:0] rb,
                         input logic rd, input logic wr, input logic [31:0] k);
    cfg_ent_we = 1; cfg_ent_idx = 8'(i); cfg_ent_valid = v; cfg_ent_subnet = s;
    cfg_ent_comp = c; cfg_ent_rbase = rb; cfg_ent_rd = rd; cfg_ent_wr = wr; cfg_ent_key = k;
  endtask

  task automatic commit_ent();
    m_v[cfg_ent_idx] = cfg_ent_valid; m_sub[cfg_ent_idx] = cfg_ent_subnet;
    m_cid[cfg_ent_idx] = cfg_ent_comp; m_rb[cfg_ent_idx] = cfg_ent_rbase;
    m_rd[cfg_ent_idx] = cfg_ent_rd; m_wr[cfg_ent_idx] = cfg_ent_wr;
    m_key[cfg_ent_idx] = cfg_ent_key;
  endtask

  task automatic wr_grid(input int g, input logic [63:0] st, input logic [4:0] lg,
                         input logic [19:0] cnt, input logic [7:0] base, input logic en);
    set_grid(g, st, lg, cnt, base, en);
    @(posedge clk); #1 cfg_grid_we = 0;
    commit_grid();
  endtask

  task automatic wr_pat(input int i);
    logic [7:0] b;
    b = 8'(i);
    set_ent(i, 1'b1, 16'h0100 + 16'(i), 12'h200 + 12'(i), {16'h0, b, 40'h0},
            ~b[1], ~b[0], 32'hC0DE_0000 + 32'(i));
    @(posedge clk); #1 cfg_ent_we = 0;
    commit_ent();
  endtask

  // driver: presents a request, records the expected response at acceptance
  task automatic send(input logic [63:0] a, input logic w, input string tag);
    req_addr = a; req_write = w; req_valid = 1;
    @(negedge clk);
    if (!bp) chk(req_ready, "R10", "req_ready under no backpressure", 64'(req_ready), 64'd1);
    while (!req_ready) @(negedge clk);
    q_exp.push_back(predict(a, w)); q_tag.push_back(tag);
    @(posedge clk); #1 req_valid = 0;
  endtask

  // request accepted on the same edge as a configuration write (R11)
  task automatic send_with_cfg(input logic [63:0] a, input string tag);
    req_addr = a; req_write = 0; req_valid = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    q_exp.push_back(predict(a, 1'b0)); q_tag.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0;
    if (cfg_grid_we) begin cfg_grid_we = 0; commit_grid(); end
    if (cfg_ent_we)  begin cfg_ent_we = 0;  commit_ent();  end
  endtask

  always @(posedge clk) begin
    #1;
    if (bp) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rsp_ready = lfsr[0] | lfsr[2];
    end else rsp_ready = 1'b1;
  end

  // monitor / scoreboard
  bit   stall_seen = 0;
  exp_t held;
  always @(negedge clk) begin
    exp_t got, e;
    string t;
    if (!rst) begin
      got = {rsp_fault, rsp_cause, rsp_subnet, rsp_comp, rsp_addr, rsp_key, rsp_rd_en};
      if (stall_seen)
        chk(rsp_valid && got == held, "R10", "held response changed",
            got[63:0], held[63:0]);
      stall_seen = rsp_valid && !rsp_ready;
      held = got;
      if (rsp_valid && rsp_ready) begin
        if (q_exp.size() == 0) chk(1'b0, "R9", "response without request", 64'd1, 64'd0);
        else begin
          e = q_exp.pop_front(); t = q_tag.pop_front();
          checks++;
          if (got !== e) begin
            errors++;
            $display("FAIL %s: got f=%0d c=%0d s=%h k=%h a=%h k=%h rd=%0d expected f=%0d c=%0d s=%h k=%h a=%h k=%h rd=%0d",
                     t, got.fault, got.cause, got.sub, got.cid, got.addr, got.key, got.rd,
                     e.fault, e.cause, e.sub, e.cid, e.addr, e.key, e.rd);
          end
        end
      end
    end
  end

  initial begin
    for (int g = 0; g < 8; g++) begin
      g_en[g] = 0; g_start[g] = 0; g_lg[g] = 12; g_cnt[g] = 0; g_base[g] = 0;
    end
    for (int i = 0; i < 256; i++) begin
      m_v[i] = 0; m_sub[i] = 0; m_cid[i] = 0; m_rb[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_key[i] = 0;
    end
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!rsp_valid, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk(req_ready, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    @(posedge clk); #1;
    send(64'h1000_0000, 0, "R1 no grid after reset");

    for (int i = 0; i < 16; i++) wr_pat(i);
    for (int i = 40; i < 44; i++) wr_pat(i);
    set_ent(250, 1, 16'hBEEF, 12'hABC, 64'h80_0000_0000, 1, 1, 32'h1234_5678);
    @(posedge clk); #1 cfg_ent_we = 0; commit_ent();
    for (int i = 252; i < 256; i++) wr_pat(i);

    wr_grid(0, 64'h1000_0000, 12, 16, 0, 1);
    wr_grid(1, 64'h1000_8000, 12, 4, 100, 1);
    wr_grid(2, 64'h40_0000_0000, 30, 2, 250, 1);
    wr_grid(3, 64'h2000_0000, 21, 8, 252, 1);
    wr_grid(4, 64'h3000_0000, 12, 4, 0, 0);
    wr_grid(5, 64'h3000_0000, 12, 4, 40, 1);
    wr_grid(6, 64'h5000_0000, 11, 1, 0, 1);   // rejected, lg below range
    wr_grid(0, 64'h0, 31, 1, 200, 1);         // rejected, lg above range

    send(64'h1000_0004, 0, "R2 first page");
    send(64'h1000_FFFF, 0, "R2 last byte of grid");
    send(64'h0FFF_FFFF, 0, "R2 below start");
    send(64'h1001_0000, 0, "R2 one past end");
    send(64'h1000_8123, 0, "R3 overlap lowest grid");
    send(64'h3000_1004, 0, "R3 disabled lower grid skipped");
    send(64'h2000_0000 + 3*64'h20_0000 + 5, 0, "R4 last table entry");
    send(64'h2000_0000 + 4*64'h20_0000, 0, "R4 index beyond table");
    send(64'h40_4000_0010, 0, "R5 invalid entry");
    send(64'h40_4000_0010, 1, "R6 invalid beats write denied");
    send(64'h1000_3010, 1, "R6 write denied");
    send(64'h1000_3010, 0, "R6 read of write-protected");
    send(64'h1000_2010, 1, "R6 write allowed");
    send(64'h40_1234_5678, 0, "R7 1G page offset");
    send(64'h5000_0000, 0, "R8 rejected size keeps grid off");
    send(64'h1000_0ABC, 0, "R8 rejected size keeps old grid");
    wr_grid(6, 64'h5000_0000, 13, 2, 2, 1);
    send(64'h5000_2008, 0, "R8 accepted size 13");

    while (q_exp.size() > 0) @(posedge clk);
    @(posedge clk); #1;
    send(64'h1000_1000, 0, "R9 latency item");
    @(negedge clk);
    chk(!rsp_valid, "R9", "rsp_valid one half cycle after accept", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    chk(rsp_valid, "R9", "rsp_valid after next edge", 64'(rsp_valid), 64'd1);
    @(posedge clk); #1;

    set_ent(2, 1, 16'h7777, 12'h777, 64'h77_0000_0000, 1, 1, 32'h7777_7777);
    send_with_cfg(64'h1000_2040, "R11 entry write same edge old");
    send(64'h1000_2040, 0, "R11 entry write later new");
    set_grid(7, 64'h6000_0000, 12, 1, 4, 1);
    send_with_cfg(64'h6000_0000, "R11 grid write same edge old");
    send(64'h6000_0000, 0, "R11 grid write later new");

    for (int i = 0; i < 8; i++) send(64'h1000_0000 + 64'(i) * 64'h1000 + 64'(i), 0, "R10 back-to-back");

    bp = 1;
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a;
      case (i % 5)
        0: a = 64'h1000_0000 + 64'(i) * 64'h400;
        1: a = 64'h2000_0000 + 64'(i) * 64'h4_0000;
        2: a = 64'h40_0000_0000 + 64'(i) * 64'h100_0000;
        3: a = 64'h3000_0000 + 64'(i) * 64'h100;
        default: a = 64'h0FFF_F000 + 64'(i) * 64'h1000;
      endcase
      send(a, 1'(i / 5), "R10 backpressure order");
    end
    while (q_exp.size() > 0) @(posedge clk);
    bp = 0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog expired: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule